// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat burst to a synchronous memory. A starting address is captured from the external address bus when one of two address strobes qualifies it. After that, each clock cycle with the active-low advance input asserted moves the burst one beat forward. Only the two low-order address bits change. The upper bits keep the value captured at the start for the whole burst.

The order of the low bits is set by a static order-select input. When it is low, the low bits count up by one modulo four from the start value (linear order). When it is high, the low bits are the start value XOR a beat count (interleaved order). A cycle with advance deasserted is a wait cycle, and the current address is held. Advancing past the fourth beat wraps the sequence back to the start value. The outputs are the registered current address and the registered beat index.

There are two load sources. The processor strobe loads only when the chip enable is also low. The controller strobe loads unconditionally. A load always wins over an advance in the same cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: With `proc_stb_n` low and `chip_en_n` low on a rising edge, after that edge `cur_addr` equals the `start_addr` sampled at that edge and `beat_idx` is 0.
- R2: With `ctrl_stb_n` low on a rising edge, the address is loaded as in R1 whatever the level of `chip_en_n`.
- R3: With `proc_stb_n` low, `chip_en_n` high and `ctrl_stb_n` high, no load happens. The upper address bits are unchanged, and the beat index holds or advances only as `adv_n` dictates.
- R4: With `order_sel` = 0 (linear), the low two bits of `cur_addr` equal (s + k) mod 4. Here s is the loaded start low bits and k is `beat_idx`. Example for s = 01: 01, 10, 11, 00.
- R5: With `order_sel` = 1 (interleaved), the low two bits of `cur_addr` equal s XOR k. Example for s = 10: 10, 11, 00, 01.
- R6: A cycle with no load and `adv_n` high is a wait cycle. After it, `cur_addr` and `beat_idx` are unchanged, provided `order_sel` is unchanged.
- R7: On any cycle with no load, `cur_addr[ADDR_W-1:2]` keeps its value.
- R8: When a load and `adv_n` low occur on the same edge, the load wins: `beat_idx` becomes 0 and `cur_addr` becomes the new start address.
- R9: An advance from beat 3 wraps to beat 0, and the low bits return to the start value s.
- R10: Synchronous active-high `rst` clears `cur_addr` and `beat_idx` to 0 on the next rising edge.
- R11: Each cycle with no load and `adv_n` low increments `beat_idx` by one modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | ADDR_W | External starting address |
| proc_stb_n | input | 1 | Processor address strobe, active low, qualified by chip_en_n |
| ctrl_stb_n | input | 1 | Controller address strobe, active low, unqualified |
| chip_en_n | input | 1 | Chip enable that qualifies the processor strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high means a wait cycle |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| cur_addr | output | ADDR_W | Registered current burst address |
| beat_idx | output | 2 | Registered beat index within the burst |

## Verification
The assertions check the following on every cycle: each load, the hold of the upper bits, the beat step and its wrap, the wait-cycle hold, the load-over-advance priority and the reset. The mapping of the low bits in each order depends on the captured start value, which is not visible at the ports. That mapping, including the return to the start value after wrap in both orders, is therefore shown only by the bench scenarios that compare full addresses against sequences worked out by hand. The bench scenarios also show that a gated processor strobe does not disturb a burst that is still advancing.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_load_qual.sv
module burst_load_qual (
  input  logic proc_stb_n,
  input  logic ctrl_stb_n,
  input  logic chip_en_n,
  output logic load
);
  logic proc_hit;
  logic ctrl_hit;

  assign proc_hit = ~proc_stb_n & ~chip_en_n;
  assign ctrl_hit = ~ctrl_stb_n;
  assign load     = proc_hit | ctrl_hit;
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv_n,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_nxt
);
  localparam logic [BEAT_W-1:0] STEP = BEAT_W'(1);

  always_comb begin
    if (load)        beat_nxt = '0;
    else if (!adv_n) beat_nxt = beat_q + STEP;
    else             beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_addr_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] low_out
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = start_low + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = start_low[b] ^ beat[b];
  end

  assign low_out = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BEAT_W-1:0] beat_idx
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              load;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nxt;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_nxt;
  logic [BEAT_W-1:0] low_nxt;
  logic [ADDR_W-1:0] cur_q;
  burst_order_e      order;

  assign order = burst_order_e'(order_sel);

  burst_load_qual u_qual (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .chip_en_n  (chip_en_n),
    .load       (load)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .adv_n    (adv_n),
    .beat_q   (beat_q),
    .beat_nxt (beat_nxt)
  );

  assign base_nxt = load ? start_addr : base_q;

  burst_low_map #(.BEAT_W(BEAT_W)) u_map (
    .start_low (base_nxt[BEAT_W-1:0]),
    .beat      (beat_nxt),
    .order     (order),
    .low_out   (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      base_q <= base_nxt;
      cur_q  <= {base_nxt[ADDR_W-1 -: UPPER_W], low_nxt};
    end
  end

  assign cur_addr = cur_q;
  assign beat_idx = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] start_addr,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              chip_en_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [BEAT_W-1:0] beat_idx
);
  localparam logic [BEAT_W-1:0] ONE  = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] LAST = '1;

  logic              any_load;
  logic [BEAT_W-1:0] beat_plus;

  assign any_load  = (!proc_stb_n && !chip_en_n) || !ctrl_stb_n;
  assign beat_plus = beat_idx + ONE;

  // R1
  r1_proc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && !chip_en_n) |=> (cur_addr == $past(start_addr) && beat_idx == '0));

  // R2
  r2_ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_stb_n |=> (cur_addr == $past(start_addr) && beat_idx == '0));

  // R3
  r3_proc_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && chip_en_n && ctrl_stb_n && adv_n) |=>
      ($stable(beat_idx) && $stable(cur_addr[ADDR_W-1:BEAT_W])));

  // R6
  r6_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_load && adv_n) ##1 $stable(order_sel) |-> ($stable(cur_addr) && $stable(beat_idx)));

  // R7
  r7_upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_load |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

  // R8
  r8_load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (any_load && !adv_n) |=> (beat_idx == '0));

  // R9
  r9_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_load && !adv_n && beat_idx == LAST) |=> (beat_idx == '0));

  // R10
  r10_reset_chk: assert property (@(posedge clk)
    rst |=> (cur_addr == '0 && beat_idx == '0));

  // R11
  r11_beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_load && !adv_n) |=> (beat_idx == $past(beat_plus)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_addr (start_addr),
  .proc_stb_n (proc_stb_n),
  .ctrl_stb_n (ctrl_stb_n),
  .chip_en_n  (chip_en_n),
  .adv_n      (adv_n),
  .order_sel  (order_sel),
  .cur_addr   (cur_addr),
  .beat_idx   (beat_idx)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int BW = 2;

  typedef struct packed {
    logic [7:0]    req;
    logic          pstb_n;
    logic          cstb_n;
    logic          ce_n;
    logic          adv_n;
    logic          mode;
    logic [AW-1:0] addr;
    logic [AW-1:0] exp_addr;
    logic [BW-1:0] exp_beat;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R2: controller strobe load, linear, start low bits 01
    '{8'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h12345, 18'h12345, 2'd0},
    // R4 linear steps; bus value ignored while no strobe (R7)
    '{8'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h12346, 2'd1},
    '{8'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h12347, 2'd2},
    // R6 wait cycle
    '{8'd6,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h12347, 2'd2},
    '{8'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00000, 18'h12344, 2'd3},
    // R9 linear wrap to start
    '{8'd9,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00000, 18'h12345, 2'd0},
    // R3 processor strobe gated off by chip enable
    '{8'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h0ABCD, 18'h12345, 2'd0},
    // R1 processor strobe load, interleaved, start low bits 10
    '{8'd1,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 18'h0ABCE, 18'h0ABCE, 2'd0},
    // R5 interleaved: 10,11,00,01
    '{8'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h0ABCF, 2'd1},
    '{8'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h0ABCC, 2'd2},
    '{8'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h0ABCD, 2'd3},
    // R9 interleaved wrap
    '{8'd9,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h0ABCE, 2'd0},
    '{8'd11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h0ABCF, 2'd1},
    // R8 load together with advance: load wins
    '{8'd8,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 18'h1F003, 18'h1F003, 2'd0},
    '{8'd5,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 18'h00000, 18'h1F002, 2'd1},
    // R3 gated strobe while advancing: only the advance acts
    '{8'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h1F001, 2'd2}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic          proc_stb_n = 1'b1;
  logic          ctrl_stb_n = 1'b1;
  logic          chip_en_n  = 1'b1;
  logic          adv_n      = 1'b1;
  logic          order_sel  = 1'b0;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] beat_idx;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .start_addr (start_addr),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .chip_en_n  (chip_en_n),
    .adv_n      (adv_n),
    .order_sel  (order_sel),
    .cur_addr   (cur_addr),
    .beat_idx   (beat_idx)
  );

  task automatic check(input int req, input logic [AW-1:0] ea, input logic [BW-1:0] eb);
    checks++;
    if (cur_addr !== ea) begin
      failures++;
      $display("FAIL R%0d cur_addr actual=%h expected=%h", req, cur_addr, ea);
    end
    checks++;
    if (beat_idx !== eb) begin
      failures++;
      $display("FAIL R%0d beat_idx actual=%0d expected=%0d", req, beat_idx, eb);
    end
  endtask

  task automatic drive(input logic p, input logic c, input logic e,
                       input logic a, input logic m, input logic [AW-1:0] ad);
    proc_stb_n = p; ctrl_stb_n = c; chip_en_n = e;
    adv_n = a; order_sel = m; start_addr = ad;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R10 reset state
    repeat (2) @(negedge clk);
    check(10, '0, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].pstb_n, VECS[i].cstb_n, VECS[i].ce_n,
            VECS[i].adv_n, VECS[i].mode, VECS[i].addr);
      @(negedge clk);
      check(int'(VECS[i].req), VECS[i].exp_addr, VECS[i].exp_beat);
    end

    // R10 reset in the middle of a burst
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
    rst = 1'b1;
    @(negedge clk);
    check(10, '0, '0);
    rst = 1'b0;

    // R4 linear from start low bits 11: 11,00,01,10
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00003);
    @(negedge clk);
    check(2, 18'h00003, 2'd0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk); check(4, 18'h00000, 2'd1);
    @(negedge clk); check(4, 18'h00001, 2'd2);
    @(negedge clk); check(4, 18'h00002, 2'd3);
    @(negedge clk); check(9, 18'h00003, 2'd0);

    // R6 long wait keeps the address
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 18'h3C3C3);
    repeat (3) @(negedge clk);
    check(6, 18'h00003, 2'd0);

    done = 1'b1;
    summary();
  end
endmodule